// File: doc/BRIEF.md
# Parallel OVSF Codeword Generator

This block turns a spreading factor and a code index into a complete orthogonal variable spreading factor codeword in one step. Every chip of the word is its own output bit. The word comes from a fixed doubling network of XOR gates, modelled on the Hadamard transform. No code table is stored and no counter steps through the chips. A chip of value +1 is carried as logic 0 and a chip of value -1 as logic 1.

A request is a one-cycle `start` pulse together with the spreading factor, given as its plain value (4, 8, ..., 512), and the code index. For a legal request the codeword sits on `code_word` and `word_valid` pulses in the following cycle. In that same cycle a serial view begins: it places one chip per cycle on `chip_out`, which is useful for checking the word or for feeding a spreader that needs one chip at a time. The word stays on the outputs until the next legal request.

Indices follow the code tree. For spreading factor SF and index k, the child codes at 2·SF are the word repeated (index 2k) and the word followed by its inverse (index 2k+1).

Top module: `ovsf_par_gen`

## Requirements
- R1: Reset state: `code_word` is all zero, and `word_valid`, `chip_valid`, `chip_last` and `chip_out` are low.
- R2: When `start` is sampled high with a legal spreading factor, `word_valid` is high in the next cycle only, and is low in the cycle after that unless another legal start arrives.
- R3: With N = log2(SF), bit j of `code_word` (j < SF) equals the parity of (j AND r), where r is the low N bits of the index in reversed bit order. Bit 0 is therefore always 0. Chip +1 is logic 0 and chip -1 is logic 1.
- R4: For a parent at SF with index k, the word for index 2k at 2·SF equals the parent word in bits [SF-1:0] and again in bits [2SF-1:SF]. The word for index 2k+1 holds the parent in bits [SF-1:0] and its bitwise inverse in bits [2SF-1:SF].
- R5: All bits of `code_word` at positions SF and above are 0.
- R6: Index bits at positions log2(SF) and above have no effect on the codeword.
- R7: A start whose `sf` is not a power of two from 4 to 512 is ignored. `word_valid` stays low, `code_word` is unchanged, and a running chip stream continues undisturbed.
- R8: `code_word` holds its value in every cycle without a legal start.
- R9: After a legal start, chip j of the word appears on `chip_out` with `chip_valid` high in the j-th cycle after the `word_valid` cycle, where j = 0 falls in the `word_valid` cycle itself. `chip_last` marks chip SF-1, and `chip_valid` is low in the following cycle unless a new legal start arrives.
- R10: A legal start while a chip stream is running restarts the stream at chip 0 of the new word.
- R11: Two different indices at the same SF give words that differ in exactly SF/2 of their first SF bits. This makes the codes orthogonal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request strobe, sampled on the rising edge |
| sf | input | 10 | Spreading factor as its plain value (4 to 512) |
| code_idx | input | 9 | Code index within the chosen SF |
| code_word | output | 512 | Codeword; bits below SF are valid, the rest are 0 |
| word_valid | output | 1 | One-cycle pulse when a new codeword is present |
| chip_out | output | 1 | Serial chip, with position 0 first |
| chip_valid | output | 1 | High while `chip_out` carries a chip |
| chip_last | output | 1 | High with the final chip, at position SF-1 |

## Verification
The hardest condition to reach is a request arriving while a chip stream is still running. An illegal request must leave that stream untouched, and a legal one must cut it short and restart it. The bench launches a long stream, issues a request a few cycles into it, and then follows `chip_out` chip by chip against the model. The tree relation between parent and child codes is a second hard point. The bench checks it by capturing a parent word at the ports and building the expected child words from the captured bits alone, not from the reference model.

// File: rtl/ovsf_par_gen.sv
module ovsf_par_gen #(
  parameter int LOG_MAX = 9,
  parameter int LOG_MIN = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [LOG_MAX:0]        sf,
  input  logic [LOG_MAX-1:0]      code_idx,
  output logic [(1<<LOG_MAX)-1:0] code_word,
  output logic                    word_valid,
  output logic                    chip_out,
  output logic                    chip_valid,
  output logic                    chip_last
);
  localparam int LEN = 1 << LOG_MAX;
  localparam int SFW = LOG_MAX + 1;
  localparam int LW  = $clog2(LOG_MAX + 1);

  logic [LW-1:0]      sf_log;
  logic               sf_ok, load;
  logic [LOG_MAX-1:0] low_mask;

  always_comb begin
    sf_log = '0;
    for (int i = 0; i <= LOG_MAX; i++)
      if (sf[i]) sf_log = LW'(i);
  end

  assign sf_ok    = (sf != '0) && ((sf & (sf - 1'b1)) == '0) && (sf_log >= LW'(LOG_MIN));
  assign load     = start && sf_ok;
  assign low_mask = ~({LOG_MAX{1'b1}} << sf_log);

  logic [LW-1:0]      n_q;
  logic [SFW-1:0]     sf_q;
  logic [LOG_MAX-1:0] idx_q, pos_q;
  logic               valid_q, run_q;
  logic               at_end;

  assign at_end = ({1'b0, pos_q} == sf_q - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_q     <= '0;
      sf_q    <= SFW'(1);
      idx_q   <= '0;
      valid_q <= 1'b0;
      run_q   <= 1'b0;
      pos_q   <= '0;
    end else begin
      valid_q <= load;
      if (load) begin
        n_q   <= sf_log;
        sf_q  <= sf;
        idx_q <= code_idx & low_mask;
        run_q <= 1'b1;
        pos_q <= '0;
      end else if (run_q) begin
        if (at_end) run_q <= 1'b0;
        else        pos_q <= pos_q + 1'b1;
      end
    end
  end

  logic [LOG_MAX-1:0] rev_full, rev_m;
  logic [LW-1:0]      shamt;

  for (genvar b = 0; b < LOG_MAX; b++) begin : g_rev
    assign rev_full[b] = idx_q[LOG_MAX-1-b];
  end

  assign shamt = LW'(LOG_MAX) - n_q;
  assign rev_m = rev_full >> shamt;

  logic [LEN-1:0] hw;
  assign hw[0] = 1'b0;

  for (genvar b = 0; b < LOG_MAX; b++) begin : g_lvl
    for (genvar j = 0; j < (1 << b); j++) begin : g_node
      assign hw[(1<<b)+j] = hw[j] ^ rev_m[b];
    end
  end

  for (genvar j = 0; j < LEN; j++) begin : g_out
    assign code_word[j] = hw[j] & (SFW'(j) < sf_q);
  end

  assign word_valid = valid_q;
  assign chip_valid = run_q;
  assign chip_out   = run_q & code_word[pos_q];
  assign chip_last  = run_q & at_end;
endmodule

// File: rtl/ovsf_par_gen_chk.sv
module ovsf_par_gen_chk #(
  parameter int LOG_MAX = 9
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    start,
  input logic [LOG_MAX:0]        sf,
  input logic [(1<<LOG_MAX)-1:0] code_word,
  input logic                    word_valid,
  input logic                    chip_out,
  input logic                    chip_valid,
  input logic                    chip_last
);
  logic legal;
  logic [LOG_MAX:0] sf_seen;

  assign legal = start && ($countones(sf) == 1) && (sf >= (LOG_MAX+1)'(4));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sf_seen <= (LOG_MAX+1)'(1);
    else if (legal) sf_seen <= sf;
  end

  a_r2_valid_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    legal |=> word_valid);

  a_r7_illegal_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !legal |=> !word_valid);

  a_r8_word_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !legal |=> $stable(code_word));

  a_r5_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (code_word >> sf_seen) == '0);

  a_r3_first_chip_zero: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> (chip_valid && !chip_out && !code_word[0]));

  a_r9_stream_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_last && !legal) |=> !chip_valid);

  a_r9_last_in_stream: assert property (@(posedge clk) disable iff (!rst_n)
    chip_last |-> chip_valid);
endmodule

bind ovsf_par_gen ovsf_par_gen_chk #(.LOG_MAX(LOG_MAX)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .sf(sf), .code_word(code_word),
  .word_valid(word_valid), .chip_out(chip_out), .chip_valid(chip_valid),
  .chip_last(chip_last)
);

// File: tb/ovsf_par_gen_tb.sv
module ovsf_par_gen_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [9:0]   sf = '0;
  logic [8:0]   code_idx = '0;
  logic [511:0] code_word;
  logic         word_valid, chip_out, chip_valid, chip_last;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  ovsf_par_gen dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .sf(sf), .code_idx(code_idx),
    .code_word(code_word), .word_valid(word_valid), .chip_out(chip_out),
    .chip_valid(chip_valid), .chip_last(chip_last)
  );

  task automatic chk(input bit ok, input string req, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [511:0] model(input int lg, input int idx);
    logic [511:0] w = '0;
    int r = 0;
    for (int b = 0; b < lg; b++)
      if (((idx >> b) & 1) != 0) r |= 1 << (lg - 1 - b);
    for (int j = 0; j < (1 << lg); j++) w[j] = ^(32'(j & r));
    return w;
  endfunction

  task automatic fire(input logic [9:0] s, input logic [8:0] i);
    @(negedge clk);
    sf = s; code_idx = i; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic t_reset;
    chk(code_word == '0, "R1 word", code_word, '0);
    chk({word_valid, chip_valid, chip_last, chip_out} == 4'b0, "R1 flags",
        512'({word_valid, chip_valid, chip_last, chip_out}), '0);
  endtask

  task automatic t_words;
    int lgs[5] = '{2, 3, 5, 8, 9};
    int ids[5] = '{3, 5, 19, 200, 301};
    for (int n = 0; n < 5; n++) begin
      fire(10'(1 << lgs[n]), 9'(ids[n]));
      chk(word_valid == 1'b1, "R2 valid", 512'(word_valid), 512'(1));
      chk(code_word == model(lgs[n], ids[n]), "R3 R5 word", code_word, model(lgs[n], ids[n]));
      @(negedge clk);
      chk(word_valid == 1'b0, "R2 pulse", 512'(word_valid), '0);
    end
  endtask

  task automatic t_ignore_high;
    logic [511:0] ref_w;
    fire(10'd16, 9'd5);
    ref_w = code_word;
    fire(10'd16, 9'h1F5);
    chk(code_word == ref_w, "R6 high index bits", code_word, ref_w);
    chk(code_word == model(4, 5), "R6 model", code_word, model(4, 5));
  endtask

  task automatic t_tree;
    logic [511:0] p, e;
    fire(10'd8, 9'd6);
    p = code_word;
    fire(10'd16, 9'd12);
    e = '0; e[7:0] = p[7:0]; e[15:8] = p[7:0];
    chk(code_word == e, "R4 even child", code_word, e);
    fire(10'd16, 9'd13);
    e = '0; e[7:0] = p[7:0]; e[15:8] = ~p[7:0];
    chk(code_word == e, "R4 odd child", code_word, e);
  endtask

  task automatic t_orth;
    logic [511:0] w8[8];
    logic [511:0] wb[4];
    int big[4] = '{0, 1, 255, 511};
    bit ok = 1'b1;
    for (int k = 0; k < 8; k++) begin
      fire(10'd8, 9'(k));
      w8[k] = code_word;
    end
    for (int a = 0; a < 8; a++)
      for (int b = a + 1; b < 8; b++)
        if ($countones(w8[a] ^ w8[b]) != 4) ok = 1'b0;
    chk(ok, "R11 SF8 pairs", 512'(ok), 512'(1));
    ok = 1'b1;
    for (int k = 0; k < 4; k++) begin
      fire(10'd512, 9'(big[k]));
      wb[k] = code_word;
    end
    for (int a = 0; a < 4; a++)
      for (int b = a + 1; b < 4; b++)
        if ($countones(wb[a] ^ wb[b]) != 256) ok = 1'b0;
    chk(ok, "R11 SF512 pairs", 512'(ok), 512'(1));
  endtask

  task automatic t_serial(input int lg, input int idx);
    logic [511:0] e;
    bit ok = 1'b1;
    e = model(lg, idx);
    fire(10'(1 << lg), 9'(idx));
    for (int k = 0; k < (1 << lg); k++) begin
      if (!chip_valid || chip_out != e[k] || chip_last != (k == (1 << lg) - 1)) ok = 1'b0;
      @(negedge clk);
    end
    chk(ok, "R9 stream chips", 512'(ok), 512'(1));
    chk(chip_valid == 1'b0, "R9 stream stops", 512'(chip_valid), '0);
  endtask

  task automatic t_restart;
    logic [511:0] e;
    bit ok = 1'b1;
    fire(10'd64, 9'd9);
    repeat (4) @(negedge clk);
    e = model(3, 3);
    fire(10'd8, 9'd3);
    for (int k = 0; k < 8; k++) begin
      if (!chip_valid || chip_out != e[k] || chip_last != (k == 7)) ok = 1'b0;
      @(negedge clk);
    end
    chk(ok, "R10 restart stream", 512'(ok), 512'(1));
    chk(chip_valid == 1'b0, "R10 restart ends", 512'(chip_valid), '0);
  endtask

  task automatic t_illegal;
    logic [511:0] old, e;
    logic [9:0] bad[5] = '{10'd0, 10'd1, 10'd2, 10'd6, 10'd768};
    fire(10'd32, 9'd7);
    repeat (40) @(negedge clk);
    old = code_word;
    for (int n = 0; n < 5; n++) begin
      fire(bad[n], 9'd1);
      chk(word_valid == 1'b0, "R7 no valid", 512'(word_valid), '0);
      chk(code_word == old && !chip_valid, "R7 unchanged", code_word, old);
    end
    e = model(4, 3);
    fire(10'd16, 9'd3);
    fire(10'd6, 9'd2);
    chk(chip_valid && chip_out == e[2] && !word_valid, "R7 stream undisturbed",
        512'({chip_valid, chip_out, word_valid}), 512'({1'b1, e[2], 1'b0}));
    chk(code_word == e, "R7 word kept", code_word, e);
  endtask

  task automatic t_hold;
    logic [511:0] w;
    fire(10'd128, 9'd77);
    w = code_word;
    repeat (20) @(negedge clk);
    chk(code_word == w && !word_valid, "R8 hold", code_word, w);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk) rst_n = 1'b1;
    t_words();
    t_ignore_high();
    t_tree();
    t_orth();
    t_serial(2, 1);
    t_serial(9, 300);
    t_restart();
    t_illegal();
    t_hold();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1000000;
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule